// File: doc/BRIEF.md
# Banked Register Stack File

This block is a stack of data registers organised as four banks of eight 32-bit fixed-point words. A user port reaches the selected bank through a top-of-stack pointer, so that ST(i) names the physical slot (top + i) modulo 8. One command is accepted per cycle: push, pop, read ST(i), write ST(i), select a bank, reinitialise, or restore the status word. Each command completes in one cycle.

A sequencer port reads any bank and slot directly, including the internal scratch bank 3, and writes them. The top pointer and the eight valid bits form one status word. This word is shared by all banks, so it is not kept per bank. Selecting another bank carries the current status over unchanged. Software that wants to see the earlier contents of a bank again samples the status word and later restores it. Stored data are never cleared by a bank switch or by reinitialising.

Top module: `bank_stack_file`

## Requirements
- R1: Command codes on `op_i`: 0 none, 1 push, 2 pop, 3 read, 4 write, 5 select, 6 reinitialise, 7 restore. A push onto an empty slot decrements the top pointer modulo 8 and stores `wdata_i` in the new ST(0) of the current bank, marking that slot valid.
- R2: A pop of a valid ST(0) sets `rdata_o` to its value on the next cycle, with `rdata_valid_o` high for that one cycle. It also marks the slot empty and increments the top pointer modulo 8.
- R3: A read of ST(`idx_i`) returns the word in physical slot (top + idx) mod 8 of the current bank on `rdata_o` the next cycle, with `rdata_valid_o` high.
- R4: A write of ST(`idx_i`) stores `wdata_i` in physical slot (top + idx) mod 8 of the current bank and marks that slot valid. The top pointer is unchanged.
- R5: A push onto a valid slot, or a read or pop of an empty slot, sets the sticky `fault_o`. That command then leaves the data, the top pointer and the valid bits unchanged. `fault_o` stays set until a reinitialise command.
- R6: Selecting bank 0, 1 or 2 changes `bank_o` and keeps the data in every bank. The status word is unchanged by the switch and applies to the new bank.
- R7: Selecting bank 3 from the user port leaves `bank_o` unchanged and sets `fault_o`.
- R8: Reinitialise clears all valid bits, sets the top pointer to 0 and clears `fault_o`. Stored data are untouched.
- R9: `status_o` is {top[2:0] in bits 10:8, valid[7:0] in bits 7:0, bit k for physical slot k}. Restore loads it from `status_i`, so that earlier entries are visible again in their former ST(i) order.
- R10: `seq_rdata_o` shows combinationally the word at (`seq_bank_i`, `seq_slot_i`) for any bank. With `seq_we_i` high, `seq_wdata_i` is stored there at the clock edge, and the user command in that cycle is ignored.
- R11: After reset the top pointer, valid bits, `bank_o`, `fault_o`, `rdata_o` and `rdata_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | User command code |
| idx_i | input | 3 | Stack-relative index i of ST(i) |
| wdata_i | input | 32 | Data for push and write |
| bank_sel_i | input | 2 | Bank named by a select command |
| status_i | input | 11 | Status word for restore |
| seq_we_i | input | 1 | Sequencer write strobe |
| seq_bank_i | input | 2 | Sequencer bank address |
| seq_slot_i | input | 3 | Sequencer physical slot address |
| seq_wdata_i | input | 32 | Sequencer write data |
| seq_rdata_o | output | 32 | Sequencer read data |
| rdata_o | output | 32 | Data returned by read or pop |
| rdata_valid_o | output | 1 | One-cycle strobe for rdata_o |
| bank_o | output | 2 | Currently selected bank |
| status_o | output | 11 | Top pointer and valid bits |
| fault_o | output | 1 | Sticky stack-fault flag |

## Verification
The bench builds the block with its default parameters: four banks, eight slots and 32-bit words. With eight slots, a full stack and the wraparound of the top pointer in both directions come within reach after a few pushes. With four banks, the rejected scratch bank and sequencer access to it are both exercised. A behavioural model driven by the same commands is compared on every cycle: status, bank, fault, returned data and the sequencer read.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_PUSH    = 3'd1,
        OP_POP     = 3'd2,
        OP_READ    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_SELECT  = 3'd5,
        OP_INIT    = 3'd6,
        OP_RESTORE = 3'd7
    } bsf_op_e;

endpackage

// File: rtl/bsf_storage.sv
module bsf_storage #(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 8,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SLOT_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    // user-side port: write and read share one address
    input  logic              u_we_i,
    input  logic [BANK_W-1:0] u_bank_i,
    input  logic [SLOT_W-1:0] u_slot_i,
    input  logic [DATA_W-1:0] u_wdata_i,
    output logic [DATA_W-1:0] u_rdata_o,
    // sequencer port: direct physical access, wins over user side
    input  logic              s_we_i,
    input  logic [BANK_W-1:0] s_bank_i,
    input  logic [SLOT_W-1:0] s_slot_i,
    input  logic [DATA_W-1:0] s_wdata_i,
    output logic [DATA_W-1:0] s_rdata_o
);

    localparam int ENTRIES = NUM_BANKS * DEPTH;
    localparam int ADDR_W  = BANK_W + SLOT_W;

    logic [DATA_W-1:0] mem_q [ENTRIES];
    logic [DATA_W-1:0] mem_d [ENTRIES];

    logic [ADDR_W-1:0] u_addr;
    logic [ADDR_W-1:0] s_addr;

    assign u_addr = {u_bank_i, u_slot_i};
    assign s_addr = {s_bank_i, s_slot_i};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_comb begin
            mem_d[e] = mem_q[e];
            if (s_we_i && (s_addr == ADDR_W'(e))) begin
                mem_d[e] = s_wdata_i;
            end else if (u_we_i && (u_addr == ADDR_W'(e))) begin
                mem_d[e] = u_wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[e] <= '0;
            end else begin
                mem_q[e] <= mem_d[e];
            end
        end
    end

    assign u_rdata_o = mem_q[u_addr];
    assign s_rdata_o = mem_q[s_addr];

    // R10: the top gates user commands while the sequencer writes
    p_single_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(u_we_i && s_we_i));

    // R10: a sequencer write is visible at its address on the next cycle
    p_seq_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we_i && (s_bank_i == u_bank_i) && (s_slot_i == u_slot_i))
        |=> (mem_q[$past(s_addr)] == $past(s_wdata_i)));

endmodule

// File: rtl/bsf_stack_ctrl.sv
module bsf_stack_ctrl
    import bsf_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 8,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SLOT_W   = $clog2(DEPTH),
    localparam int STAT_W   = SLOT_W + DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bsf_op_e           op_i,
    input  logic [SLOT_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [SLOT_W-1:0] mem_slot_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [STAT_W-1:0] status_o,
    output logic              fault_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_valid_o
);

    localparam logic [BANK_W-1:0] SCRATCH_BANK = BANK_W'(NUM_BANKS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] top;
        logic [DEPTH-1:0]  valid;
        logic [BANK_W-1:0] bank;
        logic              fault;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic [SLOT_W-1:0] slot;
    logic              slot_full;

    // physical slot addressed by the current command
    always_comb begin
        unique case (op_i)
            OP_PUSH:            slot = st_q.top - SLOT_W'(1);
            OP_READ, OP_WRITE:  slot = st_q.top + idx_i;
            default:            slot = st_q.top;
        endcase
    end

    assign slot_full = st_q.valid[slot];

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = wdata_i;
        unique case (op_i)
            OP_PUSH: begin
                if (slot_full) begin
                    st_d.fault = 1'b1;
                end else begin
                    mem_we_o          = 1'b1;
                    st_d.valid[slot]  = 1'b1;
                    st_d.top          = slot;
                end
            end
            OP_POP: begin
                if (!slot_full) begin
                    st_d.fault = 1'b1;
                end else begin
                    st_d.rdata       = mem_rdata_i;
                    st_d.rvalid      = 1'b1;
                    st_d.valid[slot] = 1'b0;
                    st_d.top         = st_q.top + SLOT_W'(1);
                end
            end
            OP_READ: begin
                if (!slot_full) begin
                    st_d.fault = 1'b1;
                end else begin
                    st_d.rdata  = mem_rdata_i;
                    st_d.rvalid = 1'b1;
                end
            end
            OP_WRITE: begin
                mem_we_o         = 1'b1;
                st_d.valid[slot] = 1'b1;
            end
            OP_SELECT: begin
                if (bank_sel_i == SCRATCH_BANK) begin
                    st_d.fault = 1'b1;
                end else begin
                    st_d.bank = bank_sel_i;
                end
            end
            OP_INIT: begin
                st_d.top   = '0;
                st_d.valid = '0;
                st_d.fault = 1'b0;
            end
            OP_RESTORE: begin
                st_d.top   = status_i[STAT_W-1:DEPTH];
                st_d.valid = status_i[DEPTH-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_slot_o    = slot;
    assign bank_o        = st_q.bank;
    assign status_o      = {st_q.top, st_q.valid};
    assign fault_o       = st_q.fault;
    assign rdata_o       = st_q.rdata;
    assign rdata_valid_o = st_q.rvalid;

    // R1: an accepted push moves the top pointer down by one
    p_push_moves_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH && !st_q.valid[st_q.top - SLOT_W'(1)])
        |=> ((st_q.top + SLOT_W'(1)) == $past(st_q.top)));

    // R2: an accepted pop strobes data and empties the old top slot
    p_pop_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_POP && st_q.valid[st_q.top])
        |=> (rdata_valid_o && !st_q.valid[$past(st_q.top)]));

    // R5: the fault flag only falls through a reinitialise
    p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fault && op_i != OP_INIT) |=> st_q.fault);

    // R5: a rejected push leaves the status word alone
    p_reject_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH && st_q.valid[st_q.top - SLOT_W'(1)])
        |=> ($stable(status_o) && fault_o));

    // R7: the scratch bank cannot be selected from the user side
    p_scratch_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SELECT && bank_sel_i == SCRATCH_BANK)
        |=> ($stable(bank_o) && fault_o));

    // R8: reinitialise empties the stack
    p_init_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INIT) |=> (status_o == '0 && !fault_o));

endmodule

// File: rtl/bank_stack_file.sv
module bank_stack_file
    import bsf_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 8,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SLOT_W   = $clog2(DEPTH),
    localparam int STAT_W   = SLOT_W + DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [SLOT_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic              seq_we_i,
    input  logic [BANK_W-1:0] seq_bank_i,
    input  logic [SLOT_W-1:0] seq_slot_i,
    input  logic [DATA_W-1:0] seq_wdata_i,
    output logic [DATA_W-1:0] seq_rdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_valid_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [STAT_W-1:0] status_o,
    output logic              fault_o
);

    bsf_op_e           op_eff;
    logic [SLOT_W-1:0] mem_slot;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    // a sequencer write takes the cycle; the user command is dropped
    assign op_eff = seq_we_i ? OP_NOP : bsf_op_e'(op_i);

    bsf_stack_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .DEPTH     (DEPTH),
        .DATA_W    (DATA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_i          (op_eff),
        .idx_i         (idx_i),
        .wdata_i       (wdata_i),
        .bank_sel_i    (bank_sel_i),
        .status_i      (status_i),
        .mem_rdata_i   (mem_rdata),
        .mem_slot_o    (mem_slot),
        .mem_we_o      (mem_we),
        .mem_wdata_o   (mem_wdata),
        .bank_o        (bank_o),
        .status_o      (status_o),
        .fault_o       (fault_o),
        .rdata_o       (rdata_o),
        .rdata_valid_o (rdata_valid_o)
    );

    bsf_storage #(
        .NUM_BANKS (NUM_BANKS),
        .DEPTH     (DEPTH),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .u_we_i    (mem_we),
        .u_bank_i  (bank_o),
        .u_slot_i  (mem_slot),
        .u_wdata_i (mem_wdata),
        .u_rdata_o (mem_rdata),
        .s_we_i    (seq_we_i),
        .s_bank_i  (seq_bank_i),
        .s_slot_i  (seq_slot_i),
        .s_wdata_i (seq_wdata_i),
        .s_rdata_o (seq_rdata_o)
    );

    // R10: during a sequencer write the user-visible status holds
    p_seq_blocks_user_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we_i |=> ($stable(status_o) && $stable(bank_o) && !rdata_valid_o));

    // R6: a bank switch never touches the status word
    p_switch_keeps_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_we_i && op_i == 3'd5) |=> $stable(status_o));

endmodule

// File: tb/bank_stack_file_tb.sv
module bank_stack_file_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_i;
    logic [2:0]  idx_i;
    logic [31:0] wdata_i;
    logic [1:0]  bank_sel_i;
    logic [10:0] status_i;
    logic        seq_we_i;
    logic [1:0]  seq_bank_i;
    logic [2:0]  seq_slot_i;
    logic [31:0] seq_wdata_i;
    logic [31:0] seq_rdata_o;
    logic [31:0] rdata_o;
    logic        rdata_valid_o;
    logic [1:0]  bank_o;
    logic [10:0] status_o;
    logic        fault_o;

    always #10 clk = ~clk;

    bank_stack_file u_dut (
        .clk (clk), .rst_n (rst_n), .op_i (op_i), .idx_i (idx_i),
        .wdata_i (wdata_i), .bank_sel_i (bank_sel_i), .status_i (status_i),
        .seq_we_i (seq_we_i), .seq_bank_i (seq_bank_i), .seq_slot_i (seq_slot_i),
        .seq_wdata_i (seq_wdata_i), .seq_rdata_o (seq_rdata_o),
        .rdata_o (rdata_o), .rdata_valid_o (rdata_valid_o), .bank_o (bank_o),
        .status_o (status_o), .fault_o (fault_o)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference
    logic [31:0] m_mem [4][8];
    bit          m_valid [8];
    int          m_top = 0;
    int          m_bank = 0;
    bit          m_fault = 0;
    bit          m_rv = 0;
    logic [31:0] m_rdata = '0;

    function automatic logic [10:0] m_status();
        logic [10:0] s;
        s[10:8] = 3'(m_top);
        for (int k = 0; k < 8; k++) s[k] = m_valid[k];
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(status_o == m_status(), tag, "status", 32'(status_o), 32'(m_status()));
        chk(bank_o == 2'(m_bank), tag, "bank", 32'(bank_o), 32'(m_bank));
        chk(fault_o == m_fault, tag, "fault", 32'(fault_o), 32'(m_fault));
        chk(rdata_valid_o == m_rv, tag, "rvalid", 32'(rdata_valid_o), 32'(m_rv));
        chk(rdata_o == m_rdata, tag, "rdata", rdata_o, m_rdata);
        chk(seq_rdata_o == m_mem[seq_bank_i][seq_slot_i], tag, "seq_rdata",
            seq_rdata_o, m_mem[seq_bank_i][seq_slot_i]);
    endtask

    // drive one cycle at a falling edge, update model at the rising edge,
    // compare at the next falling edge
    task automatic step(input int op, input int idx, input logic [31:0] d,
                        input int bsel, input logic [10:0] stat,
                        input bit swe, input int sb, input int ss,
                        input logic [31:0] sd, input string tag);
        int p;
        op_i = 3'(op); idx_i = 3'(idx); wdata_i = d; bank_sel_i = 2'(bsel);
        status_i = stat; seq_we_i = swe; seq_bank_i = 2'(sb);
        seq_slot_i = 3'(ss); seq_wdata_i = sd;
        @(posedge clk);
        m_rv = 0;
        if (swe) begin
            m_mem[sb][ss] = sd;
        end else begin
            case (op)
                1: begin
                    p = (m_top + 7) % 8;
                    if (m_valid[p]) m_fault = 1;
                    else begin m_mem[m_bank][p] = d; m_valid[p] = 1; m_top = p; end
                end
                2: begin
                    if (!m_valid[m_top]) m_fault = 1;
                    else begin
                        m_rdata = m_mem[m_bank][m_top]; m_rv = 1;
                        m_valid[m_top] = 0; m_top = (m_top + 1) % 8;
                    end
                end
                3: begin
                    p = (m_top + idx) % 8;
                    if (!m_valid[p]) m_fault = 1;
                    else begin m_rdata = m_mem[m_bank][p]; m_rv = 1; end
                end
                4: begin
                    p = (m_top + idx) % 8;
                    m_mem[m_bank][p] = d; m_valid[p] = 1;
                end
                5: begin
                    if (bsel == 3) m_fault = 1; else m_bank = bsel;
                end
                6: begin
                    m_top = 0; m_fault = 0;
                    for (int k = 0; k < 8; k++) m_valid[k] = 0;
                end
                7: begin
                    m_top = int'(stat[10:8]);
                    for (int k = 0; k < 8; k++) m_valid[k] = stat[k];
                end
                default: ;
            endcase
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic push(input logic [31:0] d, input string tag);
        step(1, 0, d, 0, '0, 0, 0, 0, '0, tag);
    endtask
    task automatic pop(input string tag);
        step(2, 0, '0, 0, '0, 0, 0, 0, '0, tag);
    endtask
    task automatic rd(input int i, input string tag);
        step(3, i, '0, 0, '0, 0, 0, 0, '0, tag);
    endtask
    task automatic wr(input int i, input logic [31:0] d, input string tag);
        step(4, i, d, 0, '0, 0, 0, 0, '0, tag);
    endtask
    task automatic sel(input int b, input string tag);
        step(5, 0, '0, b, '0, 0, 0, 0, '0, tag);
    endtask
    task automatic reinit(input string tag);
        step(6, 0, '0, 0, '0, 0, 0, 0, '0, tag);
    endtask
    task automatic restore(input logic [10:0] s, input string tag);
        step(7, 0, '0, 0, s, 0, 0, 0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] saved;
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 8; s++) m_mem[b][s] = '0;
        for (int k = 0; k < 8; k++) m_valid[k] = 0;
        rst_n = 1'b0; op_i = '0; idx_i = '0; wdata_i = '0; bank_sel_i = '0;
        status_i = '0; seq_we_i = 1'b0; seq_bank_i = '0; seq_slot_i = '0;
        seq_wdata_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R11");
        rst_n = 1'b1;
        @(negedge clk);

        // R6 bank switch, R1 pushes into bank 1
        sel(1, "R6");
        push(32'h10, "R1");
        push(32'h20, "R1");
        push(32'h30, "R1");
        chk(status_o == 11'b101_1110_0000, "R1", "top after 3 pushes",
            32'(status_o), 32'h5E0);
        // R3 ST(i) order: newest first
        rd(0, "R3");
        chk(rdata_o == 32'h30, "R3", "ST0", rdata_o, 32'h30);
        rd(2, "R3");
        chk(rdata_o == 32'h10, "R3", "ST2", rdata_o, 32'h10);
        saved = m_status();

        // R6 status carries to bank 2; R8 init keeps data
        sel(2, "R6");
        reinit("R8");
        push(32'hA1, "R1");
        push(32'hA2, "R1");
        wr(1, 32'h55, "R4");
        rd(1, "R4");
        chk(rdata_o == 32'h55, "R4", "written ST1", rdata_o, 32'h55);
        pop("R2");
        chk(rdata_o == 32'hA2 && rdata_valid_o, "R2", "pop data", rdata_o, 32'hA2);
        step(0, 0, '0, 0, '0, 0, 0, 0, '0, "R2");

        // R9 restore bank-1 view
        sel(1, "R6");
        restore(saved, "R9");
        rd(0, "R9");
        chk(rdata_o == 32'h30, "R9", "restored ST0", rdata_o, 32'h30);
        rd(1, "R9");
        rd(2, "R9");
        chk(rdata_o == 32'h10, "R9", "restored ST2", rdata_o, 32'h10);

        // R7 scratch bank rejected
        sel(3, "R7");
        chk(bank_o == 2'd1 && fault_o, "R7", "bank after scratch select",
            32'(bank_o), 32'd1);
        pop("R5");
        reinit("R8");
        chk(fault_o == 1'b0, "R8", "fault cleared", 32'(fault_o), 32'd0);

        // R5 read and pop of empty
        rd(4, "R5");
        chk(fault_o == 1'b1, "R5", "empty read fault", 32'(fault_o), 32'd1);
        pop("R5");
        reinit("R8");

        // fill the stack with wraparound, then overfill (R1, R5)
        for (int n = 0; n < 8; n++) push(32'h100 + 32'(n), "R1");
        chk(status_o == 11'b000_1111_1111, "R1", "full stack", 32'(status_o), 32'h0FF);
        push(32'hDEAD, "R5");
        chk(fault_o == 1'b1 && status_o == 11'h0FF, "R5", "overfill",
            32'(status_o), 32'h0FF);
        rd(0, "R5");
        chk(rdata_o == 32'h107, "R5", "ST0 kept on overfill", rdata_o, 32'h107);
        pop("R2");
        pop("R2");
        reinit("R8");

        // R10 sequencer: write blocks user push, reads any bank
        step(1, 0, 32'hBAD, 0, '0, 1, 3, 5, 32'hC0FFEE, "R10");
        chk(status_o == 11'h000, "R10", "user push dropped", 32'(status_o), 32'h0);
        step(0, 0, '0, 0, '0, 0, 3, 5, '0, "R10");
        chk(seq_rdata_o == 32'hC0FFEE, "R10", "scratch readback", seq_rdata_o,
            32'hC0FFEE);
        step(0, 0, '0, 0, '0, 0, 2, 6, '0, "R10");
        step(4, 3, 32'h77, 0, '0, 1, 1, 2, 32'h99, "R10");
        // user write to ST(3) was dropped; slot 3 of bank 1 still empty
        rd(3, "R10");
        chk(fault_o == 1'b1, "R10", "dropped write left slot empty",
            32'(fault_o), 32'd1);
        step(0, 0, '0, 0, '0, 0, 1, 2, '0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule